// File: doc/BRIEF.md
# Line-Based Instruction Fetch Unit

This unit supplies instruction lines to the front end of a 12-bit word machine whose 15-bit address splits into a 3-bit field number (bits 14:12) and a 12-bit offset (bits 11:0). It keeps a fetch PC and looks it up in a small fully associative line buffer of eight-word lines. On a miss it requests the whole line from memory, with at most one request in flight. On a hit it presents a bundle downstream. The bundle carries the line data, the fetch PC and the generation tag that the core supplies. Downstream stages use the tag to discard bundles fetched on a path that has since been abandoned.

A restart from later in the pipeline redirects the unit to a new PC. It drops any claim on an in-flight fill, so a fresh request can be issued at once. A fill response that arrives in the same cycle as a restart is still written into the buffer. After each accepted bundle the PC moves to the first word of the next line. That step wraps within the current 4096-word field and never changes the field number.

Top module: `fetch_unit`

## Requirements
- R1: After a synchronous reset the fetch PC equals parameter RESET_PC (default 0) and the buffer is empty: `bnd_valid` is 0 and `cmd_valid` is 1 with `cmd_line` equal to RESET_PC[14:3].
- R2: `cmd_valid` is asserted only when no fill is outstanding, no restart is presented, and the buffer has no line matching the PC. `cmd_line` is PC[14:3]. Each newly needed line costs exactly one fill.
- R3: Once a fill command is accepted (`cmd_valid && cmd_ready`), no further command is issued until a response arrives or a restart occurs.
- R4: A response (`rsp_valid`, `rsp_line`, `rsp_data` with word k at bits [12k+11:12k]) is always written into the buffer. A PC whose line is in the buffer yields `bnd_valid` with `bnd_data` equal to that line and with no fill command.
- R5: When a bundle is accepted (`bnd_valid && bnd_ready`), `bnd_pc` is the fetch PC. The next PC is the first word (bits 2:0 zero) of the following line.
- R6: Line advance keeps PC[14:12] and wraps PC[11:0] modulo 4096. For example, 0x1FF8 is followed by 0x1000.
- R7: A restart (`restart_valid`) loads the PC from `restart_pc` and cancels the outstanding fill, so a command may be issued in the very next cycle. The first bundle accepted after a restart or reset has `bnd_first` = 1 and later ones have 0.
- R8: No bundle is presented in a cycle with a restart. A response arriving in that cycle is still stored and hits later without a new fill.
- R9: A new line goes into an entry chosen round-robin over the 4 entries. A line already present is overwritten in place.
- R10: `bnd_gen` equals `gen_in` in the cycle the bundle is accepted.
- R11: While `bnd_valid` is high and `bnd_ready` low, the PC and the bundle hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_in | input | 4 | Core-wide generation tag |
| restart_valid | input | 1 | Redirect request |
| restart_pc | input | 15 | Redirect target PC |
| cmd_valid | output | 1 | Line fill request |
| cmd_ready | input | 1 | Memory accepts the request |
| cmd_line | output | 12 | Requested line address |
| rsp_valid | input | 1 | Fill data present |
| rsp_line | input | 12 | Line address of the returned data |
| rsp_data | input | 96 | Eight 12-bit words of the line |
| bnd_valid | output | 1 | Bundle available |
| bnd_ready | input | 1 | Downstream accepts the bundle |
| bnd_pc | output | 15 | Fetch PC of the bundle |
| bnd_gen | output | 4 | Generation tag of the bundle |
| bnd_first | output | 1 | First bundle after restart or reset |
| bnd_data | output | 96 | Line data of the bundle |

## Verification
The assertions check every cycle that the PC steps line by line inside its field, holds while stalled, and takes the restart target. They also check that a command never follows an accepted one without a response in between, that no bundle appears during a restart, and that buffer tags never match twice. The bench scenarios cover the properties that depend on history. These are round-robin eviction and survival of older lines, one fill per line, the unbroken stream of data and generation values across windows, and storage of a response that coincides with a restart, proven by a later fill-free hit.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    parameter int unsigned WORD_W     = 12;
    parameter int unsigned ADDR_W     = 15;
    parameter int unsigned FIELD_W    = 3;
    parameter int unsigned LINE_WORDS = 8;
    parameter int unsigned GEN_W      = 4;

    localparam int unsigned OFS_W    = $clog2(LINE_WORDS);
    localparam int unsigned LINE_W   = ADDR_W - OFS_W;
    localparam int unsigned OFFSET_W = ADDR_W - FIELD_W;
    localparam int unsigned DATA_W   = LINE_WORDS * WORD_W;

    typedef logic [ADDR_W-1:0] pc_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [DATA_W-1:0] ldata_t;
    typedef logic [GEN_W-1:0]  gen_t;

    typedef struct packed {
        logic   first;
        gen_t   gen;
        pc_t    pc;
        ldata_t data;
    } bundle_t;

    function automatic line_t line_of(input pc_t pc);
        return pc[ADDR_W-1:OFS_W];
    endfunction

    function automatic pc_t next_line_pc(input pc_t pc);
        logic [OFFSET_W-1:0] off;
        off = pc[OFFSET_W-1:0] & ~OFFSET_W'(LINE_WORDS - 1);
        off = off + OFFSET_W'(LINE_WORDS);
        return {pc[ADDR_W-1:OFFSET_W], off};
    endfunction
endpackage

// File: rtl/ifu_line_buffer.sv
module ifu_line_buffer import ifu_pkg::*; #(
    parameter int unsigned ENTRIES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  line_t  look_line,
    output logic   hit,
    output ldata_t rd_data,
    input  logic   wr_en,
    input  line_t  wr_line,
    input  ldata_t wr_data
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    line_t              tag_q  [ENTRIES];
    ldata_t             data_q [ENTRIES];
    logic [IDX_W-1:0]   victim_q;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] wmatch;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i]  = valid_q[i] && (tag_q[i] == look_line);
        assign wmatch[i] = valid_q[i] && (tag_q[i] == wr_line);
    end

    assign hit = |match;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) rd_data = data_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            victim_q <= '0;
        end else if (wr_en) begin
            if (|wmatch) begin
                for (int i = 0; i < ENTRIES; i++)
                    if (wmatch[i]) data_q[i] <= wr_data;
            end else begin
                valid_q[victim_q] <= 1'b1;
                tag_q[victim_q]   <= wr_line;
                data_q[victim_q]  <= wr_data;
                victim_q <= (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
            end
        end
    end

    // R4
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R9
    rewrite_present_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (|wmatch)) |=> $stable(victim_q));
endmodule

// File: rtl/ifu_seq.sv
module ifu_seq import ifu_pkg::*; #(
    parameter pc_t RESET_PC = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_valid,
    input  pc_t  restart_pc,
    input  logic hit,
    input  logic cmd_ready,
    input  logic rsp_valid,
    input  logic bnd_ready,
    output pc_t  pc,
    output logic first,
    output logic cmd_valid,
    output logic bnd_valid
);
    logic pend_q;

    assign cmd_valid = !pend_q && !hit && !restart_valid;
    assign bnd_valid = hit && !restart_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= RESET_PC;
            pend_q <= 1'b0;
            first  <= 1'b1;
        end else if (restart_valid) begin
            pc     <= restart_pc;
            pend_q <= 1'b0;
            first  <= 1'b1;
        end else begin
            if (bnd_valid && bnd_ready) begin
                pc    <= next_line_pc(pc);
                first <= 1'b0;
            end
            if (cmd_valid && cmd_ready) pend_q <= 1'b1;
            else if (rsp_valid)         pend_q <= 1'b0;
        end
    end

    // R5
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid && bnd_ready) |=> (pc == next_line_pc($past(pc))));

    // R6
    field_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid && bnd_ready) |=> (pc[ADDR_W-1:OFFSET_W] == $past(pc[ADDR_W-1:OFFSET_W])));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd_valid && !bnd_ready) |=> $stable(pc));

    // R7
    redirect_load_chk: assert property (@(posedge clk) disable iff (rst)
        restart_valid |=> (pc == $past(restart_pc) && !pend_q));
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit import ifu_pkg::*; #(
    parameter int unsigned ENTRIES  = 4,
    parameter pc_t         RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GEN_W-1:0]  gen_in,
    input  logic              restart_valid,
    input  logic [ADDR_W-1:0] restart_pc,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [LINE_W-1:0] cmd_line,
    input  logic              rsp_valid,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              bnd_valid,
    input  logic              bnd_ready,
    output logic [ADDR_W-1:0] bnd_pc,
    output logic [GEN_W-1:0]  bnd_gen,
    output logic              bnd_first,
    output logic [DATA_W-1:0] bnd_data
);
    pc_t     pc;
    logic    hit;
    logic    first;
    ldata_t  line_data;
    bundle_t bnd;

    ifu_line_buffer #(.ENTRIES(ENTRIES)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .look_line(line_of(pc)),
        .hit      (hit),
        .rd_data  (line_data),
        .wr_en    (rsp_valid),
        .wr_line  (rsp_line),
        .wr_data  (rsp_data)
    );

    ifu_seq #(.RESET_PC(RESET_PC)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .restart_valid(restart_valid),
        .restart_pc   (restart_pc),
        .hit          (hit),
        .cmd_ready    (cmd_ready),
        .rsp_valid    (rsp_valid),
        .bnd_ready    (bnd_ready),
        .pc           (pc),
        .first        (first),
        .cmd_valid    (cmd_valid),
        .bnd_valid    (bnd_valid)
    );

    assign cmd_line = line_of(pc);

    always_comb begin
        bnd.first = first;
        bnd.gen   = gen_in;
        bnd.pc    = pc;
        bnd.data  = line_data;
    end

    assign bnd_pc    = bnd.pc;
    assign bnd_gen   = bnd.gen;
    assign bnd_first = bnd.first;
    assign bnd_data  = bnd.data;

    // R2
    fill_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !hit);

    // R3
    one_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R8
    quiet_on_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        restart_valid |-> !bnd_valid);
endmodule

// File: tb/tb_fetch_unit.sv
module tb_fetch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  gen_in = '0;
    logic        restart_valid = 1'b0;
    logic [14:0] restart_pc = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [11:0] cmd_line;
    logic        rsp_valid = 1'b0;
    logic [11:0] rsp_line = '0;
    logic [95:0] rsp_data = '0;
    logic        bnd_valid;
    logic        bnd_ready = 1'b0;
    logic [14:0] bnd_pc;
    logic [3:0]  bnd_gen;
    logic        bnd_first;
    logic [95:0] bnd_data;

    always #10 clk = ~clk;

    fetch_unit dut (
        .clk(clk), .rst(rst), .gen_in(gen_in),
        .restart_valid(restart_valid), .restart_pc(restart_pc),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_line(cmd_line),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_data(rsp_data),
        .bnd_valid(bnd_valid), .bnd_ready(bnd_ready), .bnd_pc(bnd_pc),
        .bnd_gen(bnd_gen), .bnd_first(bnd_first), .bnd_data(bnd_data)
    );

    int checks = 0;
    int fails  = 0;
    int cmd_count = 0;

    typedef struct {
        logic [14:0] pc;
        logic [3:0]  gen;
        logic        first;
    } exp_t;
    exp_t sb[$];

    bit          mem_en = 1'b1;
    bit          mem_busy = 1'b0;
    int          mem_cnt = 0;
    int          mem_lat = 2;
    logic [11:0] mem_line = '0;

    function automatic logic [95:0] line_image(input logic [11:0] ln);
        logic [95:0] d;
        for (int k = 0; k < 8; k++)
            d[k*12 +: 12] = (ln * 12'd5 + 12'(k)) ^ 12'hA5A;
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_bnd(input logic [14:0] pc, input logic [3:0] g, input logic f);
        exp_t e;
        e.pc = pc; e.gen = g; e.first = f;
        sb.push_back(e);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && bnd_valid && bnd_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4 unexpected bundle", 96'(bnd_pc), 96'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(bnd_pc == e.pc, "R5 bundle pc", 96'(bnd_pc), 96'(e.pc));
                chk(bnd_gen == e.gen, "R10 bundle gen", 96'(bnd_gen), 96'(e.gen));
                chk(bnd_first == e.first, "R7 bundle first flag", 96'(bnd_first), 96'(e.first));
                chk(bnd_data == line_image(e.pc[14:3]), "R4 bundle data", bnd_data, line_image(e.pc[14:3]));
            end
        end
        if (!rst && cmd_valid && cmd_ready) begin
            cmd_count++;
            if (mem_en) begin
                mem_busy = 1'b1;
                mem_line = cmd_line;
                mem_cnt  = mem_lat;
            end
        end
    end

    // memory responder
    initial begin
        forever begin
            @(posedge clk); #1;
            if (mem_en) begin
                rsp_valid = 1'b0;
                if (mem_busy) begin
                    if (mem_cnt == 0) begin
                        rsp_valid = 1'b1;
                        rsp_line  = mem_line;
                        rsp_data  = line_image(mem_line);
                        mem_busy  = 1'b0;
                    end else begin
                        mem_cnt--;
                    end
                end
            end
        end
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic drain(input string req);
        bit done = 1'b0;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            if (sb.size() == 0) begin done = 1'b1; break; end
        end
        @(posedge clk); #2;
        bnd_ready = 1'b0;
        cmd_ready = 1'b0;
        chk(done, req, 96'(sb.size()), 96'h0);
    endtask

    task automatic do_restart(input logic [14:0] p);
        @(posedge clk); #2;
        restart_valid = 1'b1;
        restart_pc = p;
        @(posedge clk); #2;
        restart_valid = 1'b0;
    endtask

    initial begin
        int c0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bnd_valid == 1'b0, "R1 no bundle after reset", 96'(bnd_valid), 96'h0);
        chk(cmd_valid == 1'b1, "R1 fill requested after reset", 96'(cmd_valid), 96'h1);
        chk(cmd_line == 12'h000, "R1 reset line", 96'(cmd_line), 96'h0);

        // R2 R4 R5 R10: sequential stream of five lines
        gen_in = 4'd3;
        expect_bnd(15'h0000, 4'd3, 1'b1);
        expect_bnd(15'h0008, 4'd3, 1'b0);
        expect_bnd(15'h0010, 4'd3, 1'b0);
        expect_bnd(15'h0018, 4'd3, 1'b0);
        expect_bnd(15'h0020, 4'd3, 1'b0);
        @(posedge clk); #2;
        cmd_ready = 1'b1; bnd_ready = 1'b1;
        drain("R5 stream drained");
        chk(cmd_count == 5, "R2 one fill per line", 96'(cmd_count), 96'd5);

        // R4 hit without fill (line 1 present)
        gen_in = 4'd4;
        c0 = cmd_count;
        expect_bnd(15'h000B, 4'd4, 1'b1);
        do_restart(15'h000B);
        bnd_ready = 1'b1;
        drain("R4 hit drained");
        chk(cmd_count == c0, "R4 hit needs no fill", 96'(cmd_count), 96'(c0));

        // R9 evicted line 0 is refetched
        expect_bnd(15'h0000, 4'd4, 1'b1);
        do_restart(15'h0000);
        cmd_ready = 1'b1; bnd_ready = 1'b1;
        drain("R9 refill drained");
        chk(cmd_count == c0 + 1, "R9 oldest line evicted", 96'(cmd_count), 96'(c0 + 1));

        // R9 round robin: line 1 was next victim
        expect_bnd(15'h0008, 4'd4, 1'b1);
        do_restart(15'h0008);
        cmd_ready = 1'b1; bnd_ready = 1'b1;
        drain("R9 second refill drained");
        chk(cmd_count == c0 + 2, "R9 round robin victim", 96'(cmd_count), 96'(c0 + 2));

        // R11 stall on a surviving line (line 4)
        c0 = cmd_count;
        do_restart(15'h0020);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(bnd_valid == 1'b1, "R11 bundle held", 96'(bnd_valid), 96'h1);
            chk(bnd_pc == 15'h0020, "R11 pc held", 96'(bnd_pc), 96'h20);
        end
        expect_bnd(15'h0020, 4'd4, 1'b1);
        @(posedge clk); #2;
        bnd_ready = 1'b1;
        drain("R11 drained");
        chk(cmd_count == c0, "R9 newer line survived", 96'(cmd_count), 96'(c0));

        // R6 field wrap
        gen_in = 4'd7;
        expect_bnd(15'h1FF8, 4'd7, 1'b1);
        expect_bnd(15'h1000, 4'd7, 1'b0);
        do_restart(15'h1FF8);
        cmd_ready = 1'b1; bnd_ready = 1'b1;
        drain("R6 wrap drained");

        // R3 single outstanding fill, R7 restart cancels it
        mem_en = 1'b0;
        do_restart(15'h0100);
        cmd_ready = 1'b1;
        c0 = cmd_count;
        repeat (5) @(negedge clk);
        chk(cmd_count == c0 + 1, "R3 only one fill issued", 96'(cmd_count), 96'(c0 + 1));
        chk(cmd_valid == 1'b0, "R3 no command while pending", 96'(cmd_valid), 96'h0);
        mem_en = 1'b1;
        expect_bnd(15'h0200, 4'd7, 1'b1);
        do_restart(15'h0200);
        @(negedge clk);
        chk(cmd_valid == 1'b1 && cmd_line == 12'h040, "R7 fill right after restart",
            96'({cmd_valid, cmd_line}), 96'({1'b1, 12'h040}));
        bnd_ready = 1'b1;
        drain("R7 drained");

        // R8 response coinciding with restart
        mem_en = 1'b0;
        c0 = cmd_count;
        @(posedge clk); #2;
        restart_valid = 1'b1; restart_pc = 15'h0300;
        rsp_valid = 1'b1; rsp_line = 12'h041; rsp_data = line_image(12'h041);
        bnd_ready = 1'b1;
        @(negedge clk);
        chk(bnd_valid == 1'b0, "R8 no bundle during restart", 96'(bnd_valid), 96'h0);
        @(posedge clk); #2;
        restart_valid = 1'b0; rsp_valid = 1'b0;
        expect_bnd(15'h0208, 4'd7, 1'b1);
        do_restart(15'h0208);
        @(negedge clk); #1;
        chk(sb.size() == 0, "R8 stored line hits", 96'(sb.size()), 96'h0);
        chk(cmd_valid == 1'b0, "R8 no refill for stored line", 96'(cmd_valid), 96'h0);
        drain("R8 drained");
        chk(cmd_count == c0, "R8 fill count", 96'(cmd_count), 96'(c0));

        chk(sb.size() == 0, "R5 scoreboard empty", 96'(sb.size()), 96'h0);
        report();
    end
endmodule